// File: doc/BRIEF.md
# IOM2 Terminal-Mode Frame Interface

This block is the serial frame engine for the terminal side of an IOM2 link. It runs directly on the double-rate data clock. From the 8 kHz frame sync it builds the frame timing: 96 bit periods per frame, with two clock cycles in each bit period. Once per frame it loads a set of parallel transmit channel registers and shifts them out on the upstream line. In the same frame it collects the downstream line into matching parallel receive registers.

The fixed terminal channel order is two user bytes (B1, B2), then monitor channel 0, then a byte that packs the D channel, command/indicate channel 0 and two handshake bits. Next come two intercommunication bytes and monitor channel 1, then a byte that packs command/indicate channel 1 and a second pair of handshake bits. Two helper outputs serve attached devices that cannot decode the frame themselves: a bit-rate clock, and a strobe that covers the B1 byte. The block handles bit timing and slotting only. It does no monitor handshaking, no D-channel framing and no command/indicate change detection.

Top module: `iom2_term_link`

## Requirements
- R1: From reset until the first rising edge of `fsync` is seen, `up_data` is 1 and `bit_clk`, `b1_strobe` and `frame_done` are 0, whatever the other inputs do.
- R2: A frame starts at the first clock edge that samples `fsync` high after sampling it low at the edge before. Bit 0 occupies the two clock cycles after that edge, and bit n occupies cycles 2n and 2n+1. A frame lasts 192 cycles.
- R3: Once framed, `bit_clk` is 0 in the first cycle of every bit period and 1 in the second. Its rate is the clock rate divided by two.
- R4: Once framed, `b1_strobe` is 1 in exactly the 16 cycles of bits 0 to 7, which is the B1 byte, and 0 in every other cycle.
- R5: `up_data` carries 64 channel bits, MSB first, one byte after another in this order: B1, B2, MON0, {D[1:0], CI0[3:0], HS-receive 0, HS-transmit 0}, IC1, IC2, MON1, {CI1[5:0], HS-receive 1, HS-transmit 1}. Each bit changes at the start of its bit period and holds for both cycles.
- R6: The transmit inputs are sampled only at the frame-start edge. A change to them during a frame does not alter the bits sent in that frame.
- R7: `up_data` is 1 in bit periods 64 to 95, which lie outside all channels.
- R8: `dn_data` is sampled at the clock edge that ends the first cycle of each bit period. Bits 0 to 63 fill the receive outputs in the same layout as R5.
- R9: The edge that ends cycle 191 copies the received bytes to the `rx_*` outputs and raises `frame_done` for exactly one cycle. The `rx_*` outputs change at no other time.
- R10: If no `fsync` edge arrives, the frame counter wraps from cycle 191 to 0 on its own. The wrap starts a new frame, with a transmit reload and a frame-done pulse.
- R11: An `fsync` edge that arrives before cycle 191 restarts the count at bit 0. The cut-short frame raises no `frame_done` and leaves the `rx_*` outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | 8 kHz frame sync |
| dn_data | input | 1 | Downstream serial data |
| tx_b1 | input | 8 | B1 byte to send |
| tx_b2 | input | 8 | B2 byte to send |
| tx_mon0 | input | 8 | Monitor 0 byte to send |
| tx_dch | input | 2 | D-channel bits to send |
| tx_cmdind0 | input | 4 | Command/indicate 0 to send |
| tx_hsr0 | input | 1 | Handshake receive bit 0 to send |
| tx_hsx0 | input | 1 | Handshake transmit bit 0 to send |
| tx_icom1 | input | 8 | Intercommunication 1 byte to send |
| tx_icom2 | input | 8 | Intercommunication 2 byte to send |
| tx_mon1 | input | 8 | Monitor 1 byte to send |
| tx_cmdind1 | input | 6 | Command/indicate 1 to send |
| tx_hsr1 | input | 1 | Handshake receive bit 1 to send |
| tx_hsx1 | input | 1 | Handshake transmit bit 1 to send |
| up_data | output | 1 | Upstream serial data |
| bit_clk | output | 1 | Bit-rate clock |
| b1_strobe | output | 1 | High during the B1 byte |
| rx_b1 | output | 8 | Received B1 byte |
| rx_b2 | output | 8 | Received B2 byte |
| rx_mon0 | output | 8 | Received monitor 0 byte |
| rx_dch | output | 2 | Received D-channel bits |
| rx_cmdind0 | output | 4 | Received command/indicate 0 |
| rx_hsr0 | output | 1 | Received handshake receive bit 0 |
| rx_hsx0 | output | 1 | Received handshake transmit bit 0 |
| rx_icom1 | output | 8 | Received intercommunication 1 byte |
| rx_icom2 | output | 8 | Received intercommunication 2 byte |
| rx_mon1 | output | 8 | Received monitor 1 byte |
| rx_cmdind1 | output | 6 | Received command/indicate 1 |
| rx_hsr1 | output | 1 | Received handshake receive bit 1 |
| rx_hsx1 | output | 1 | Received handshake transmit bit 1 |
| frame_done | output | 1 | One-cycle pulse when new receive bytes are valid |

## Verification
If the frame counter is wrong, it moves `bit_clk`, `b1_strobe` and the slot of every `up_data` bit in the very next cycle. Comparing these outputs on every cycle of a frame therefore catches an off-by-one counter or a wrong wrap at once. An error in the transmit snapshot or in the bit indexing shows as a wrong `up_data` bit within the bit period concerned. An error in the receive shift path or in end-of-frame detection is hidden until the copy edge at cycle 191. It appears one cycle into the next frame as a missing, spurious or wrong-valued `frame_done` and `rx_*` update. The early-sync and free-running frames check that the copy is tied to the end of the count and not to the sync edge.

// File: rtl/iom2t_pkg.sv
package iom2t_pkg;
    localparam int BYTE_W   = 8;
    localparam int CH_BYTES = 8;
    localparam int CH_BITS  = BYTE_W * CH_BYTES;
endpackage

// File: rtl/iom2t_timing.sv
module iom2t_timing
    import iom2t_pkg::*;
#(
    parameter int FRAME_BITS = 96,
    parameter int STRB_BYTES = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  fsync,
    output logic [$clog2(2*FRAME_BITS)-1:0]       cnt_q,
    output logic [$clog2(2*FRAME_BITS)-1:0]       cnt_nxt,
    output logic                                  lock_q,
    output logic                                  lock_nxt,
    output logic                                  sof,
    output logic                                  bit_clk,
    output logic                                  b1_strobe
);
    localparam int CYC      = 2 * FRAME_BITS;
    localparam int CW       = $clog2(CYC);
    localparam int STRB_CYC = 2 * BYTE_W * STRB_BYTES;

    typedef struct packed {
        logic          fs;
        logic          lock;
        logic [CW-1:0] cnt;
        logic          bclk;
        logic          strb;
    } tim_t;

    tim_t st_d, st_q;
    logic fs_edge, wrap;

    always_comb begin
        st_d    = st_q;
        st_d.fs = fsync;
        fs_edge = fsync & ~st_q.fs;
        wrap    = st_q.lock && (st_q.cnt == CW'(CYC - 1));
        if (fs_edge || wrap || !st_q.lock)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
        st_d.lock = st_q.lock | fs_edge;
        st_d.bclk = st_d.lock & st_d.cnt[0];
        st_d.strb = st_d.lock & (st_d.cnt < CW'(STRB_CYC));
        sof       = fs_edge | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q     = st_q.cnt;
    assign cnt_nxt   = st_d.cnt;
    assign lock_q    = st_q.lock;
    assign lock_nxt  = st_d.lock;
    assign bit_clk   = st_q.bclk;
    assign b1_strobe = st_q.strb;
endmodule

// File: rtl/iom2t_tx.sv
module iom2t_tx #(
    parameter int FRAME_BITS = 96,
    parameter int CH_BITS    = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sof,
    input  logic                                  lock_nxt,
    input  logic [$clog2(2*FRAME_BITS)-2:0]       bit_nxt,
    input  logic [CH_BITS-1:0]                    tx_vec,
    output logic                                  up_data
);
    localparam int BW = $clog2(2 * FRAME_BITS) - 1;

    typedef struct packed {
        logic [CH_BITS-1:0] snap;
        logic               du;
    } tx_t;

    tx_t st_d, st_q;
    logic [CH_BITS-1:0] shifted;

    always_comb begin
        st_d      = st_q;
        st_d.snap = sof ? tx_vec : st_q.snap;
        shifted   = st_d.snap << bit_nxt;
        if (lock_nxt && (bit_nxt < BW'(CH_BITS)))
            st_d.du = shifted[CH_BITS-1];
        else
            st_d.du = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{snap: '0, du: 1'b1};
        else        st_q <= st_d;
    end

    assign up_data = st_q.du;
endmodule

// File: rtl/iom2t_rx.sv
module iom2t_rx #(
    parameter int FRAME_BITS = 96,
    parameter int CH_BITS    = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  lock_q,
    input  logic [$clog2(2*FRAME_BITS)-1:0]       cnt_q,
    input  logic                                  dn_data,
    output logic [CH_BITS-1:0]                    rx_vec,
    output logic                                  frame_done
);
    localparam int CYC = 2 * FRAME_BITS;
    localparam int CW  = $clog2(CYC);
    localparam int BW  = CW - 1;

    typedef struct packed {
        logic [CH_BITS-1:0] sh;
        logic [CH_BITS-1:0] hold;
        logic               done;
    } rx_t;

    rx_t st_d, st_q;
    logic [BW-1:0] bit_idx;
    logic          eof;

    always_comb begin
        st_d    = st_q;
        bit_idx = cnt_q[CW-1:1];
        eof     = lock_q && (cnt_q == CW'(CYC - 1));
        if (lock_q && !cnt_q[0] && (bit_idx < BW'(CH_BITS)))
            st_d.sh = {st_q.sh[CH_BITS-2:0], dn_data};
        st_d.done = eof;
        if (eof)
            st_d.hold = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_vec     = st_q.hold;
    assign frame_done = st_q.done;
endmodule

// File: rtl/iom2_term_link.sv
module iom2_term_link
    import iom2t_pkg::*;
#(
    parameter int FRAME_BITS = 96,
    parameter int STRB_BYTES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic       dn_data,
    input  logic [7:0] tx_b1,
    input  logic [7:0] tx_b2,
    input  logic [7:0] tx_mon0,
    input  logic [1:0] tx_dch,
    input  logic [3:0] tx_cmdind0,
    input  logic       tx_hsr0,
    input  logic       tx_hsx0,
    input  logic [7:0] tx_icom1,
    input  logic [7:0] tx_icom2,
    input  logic [7:0] tx_mon1,
    input  logic [5:0] tx_cmdind1,
    input  logic       tx_hsr1,
    input  logic       tx_hsx1,
    output logic       up_data,
    output logic       bit_clk,
    output logic       b1_strobe,
    output logic [7:0] rx_b1,
    output logic [7:0] rx_b2,
    output logic [7:0] rx_mon0,
    output logic [1:0] rx_dch,
    output logic [3:0] rx_cmdind0,
    output logic       rx_hsr0,
    output logic       rx_hsx0,
    output logic [7:0] rx_icom1,
    output logic [7:0] rx_icom2,
    output logic [7:0] rx_mon1,
    output logic [5:0] rx_cmdind1,
    output logic       rx_hsr1,
    output logic       rx_hsx1,
    output logic       frame_done
);
    localparam int CW = $clog2(2 * FRAME_BITS);

    logic [CW-1:0]      cnt_q, cnt_nxt;
    logic               lock_q, lock_nxt, sof;
    logic [CH_BITS-1:0] tx_vec, rx_vec;

    assign tx_vec = {tx_b1, tx_b2, tx_mon0,
                     tx_dch, tx_cmdind0, tx_hsr0, tx_hsx0,
                     tx_icom1, tx_icom2, tx_mon1,
                     tx_cmdind1, tx_hsr1, tx_hsx1};

    assign {rx_b1, rx_b2, rx_mon0,
            rx_dch, rx_cmdind0, rx_hsr0, rx_hsx0,
            rx_icom1, rx_icom2, rx_mon1,
            rx_cmdind1, rx_hsr1, rx_hsx1} = rx_vec;

    iom2t_timing #(.FRAME_BITS(FRAME_BITS), .STRB_BYTES(STRB_BYTES)) u_tim (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
        .lock_q(lock_q), .lock_nxt(lock_nxt), .sof(sof),
        .bit_clk(bit_clk), .b1_strobe(b1_strobe)
    );

    iom2t_tx #(.FRAME_BITS(FRAME_BITS), .CH_BITS(CH_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .sof(sof), .lock_nxt(lock_nxt),
        .bit_nxt(cnt_nxt[CW-1:1]), .tx_vec(tx_vec), .up_data(up_data)
    );

    iom2t_rx #(.FRAME_BITS(FRAME_BITS), .CH_BITS(CH_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .cnt_q(cnt_q),
        .dn_data(dn_data), .rx_vec(rx_vec), .frame_done(frame_done)
    );
endmodule

// File: rtl/iom2_term_link_chk.sv
module iom2_term_link_chk #(
    parameter int CH_BITS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               locked,
    input logic               up_data,
    input logic               bit_clk,
    input logic               b1_strobe,
    input logic               frame_done,
    input logic [CH_BITS-1:0] rx_all
);
    // R1
    idle_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (up_data && !bit_clk && !b1_strobe && !frame_done));

    // R3
    bitclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk |=> !bit_clk);

    // R4
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b1_strobe) |-> !bit_clk);

    // R5
    du_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk |-> $stable(up_data));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(rx_all));

    // R2
    done_at_bit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!bit_clk && b1_strobe));
endmodule

bind iom2_term_link iom2_term_link_chk #(.CH_BITS(iom2t_pkg::CH_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .locked(lock_q), .up_data(up_data),
    .bit_clk(bit_clk), .b1_strobe(b1_strobe), .frame_done(frame_done),
    .rx_all(rx_vec)
);

// File: tb/iom2_term_link_test.sv
`timescale 1ns/1ps
module iom2_term_link_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic dn_data = 1'b1;
    logic [7:0] tx_b1, tx_b2, tx_mon0, tx_icom1, tx_icom2, tx_mon1;
    logic [1:0] tx_dch;
    logic [3:0] tx_cmdind0;
    logic [5:0] tx_cmdind1;
    logic tx_hsr0, tx_hsx0, tx_hsr1, tx_hsx1;
    logic up_data, bit_clk, b1_strobe, frame_done;
    logic [7:0] rx_b1, rx_b2, rx_mon0, rx_icom1, rx_icom2, rx_mon1;
    logic [1:0] rx_dch;
    logic [3:0] rx_cmdind0;
    logic [5:0] rx_cmdind1;
    logic rx_hsr0, rx_hsx0, rx_hsr1, rx_hsx1;

    int total = 0;
    int bad = 0;
    bit full_pending = 1'b0;
    logic [63:0] pend_rx = '0;
    logic [63:0] hold_exp = '0;

    always #4 clk = ~clk;

    iom2_term_link uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .dn_data(dn_data),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon0(tx_mon0), .tx_dch(tx_dch),
        .tx_cmdind0(tx_cmdind0), .tx_hsr0(tx_hsr0), .tx_hsx0(tx_hsx0),
        .tx_icom1(tx_icom1), .tx_icom2(tx_icom2), .tx_mon1(tx_mon1),
        .tx_cmdind1(tx_cmdind1), .tx_hsr1(tx_hsr1), .tx_hsx1(tx_hsx1),
        .up_data(up_data), .bit_clk(bit_clk), .b1_strobe(b1_strobe),
        .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon0(rx_mon0), .rx_dch(rx_dch),
        .rx_cmdind0(rx_cmdind0), .rx_hsr0(rx_hsr0), .rx_hsx0(rx_hsx0),
        .rx_icom1(rx_icom1), .rx_icom2(rx_icom2), .rx_mon1(rx_mon1),
        .rx_cmdind1(rx_cmdind1), .rx_hsr1(rx_hsr1), .rx_hsx1(rx_hsx1),
        .frame_done(frame_done)
    );

    function automatic logic [63:0] rx_now();
        return {rx_b1, rx_b2, rx_mon0, rx_dch, rx_cmdind0, rx_hsr0, rx_hsx0,
                rx_icom1, rx_icom2, rx_mon1, rx_cmdind1, rx_hsr1, rx_hsx1};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R5 layout: B1, B2, MON0, {D,CI0,HSR0,HSX0}, IC1, IC2, MON1, {CI1,HSR1,HSX1}
    task automatic drive_tx(input logic [63:0] v);
        {tx_b1, tx_b2, tx_mon0, tx_dch, tx_cmdind0, tx_hsr0, tx_hsx0,
         tx_icom1, tx_icom2, tx_mon1, tx_cmdind1, tx_hsr1, tx_hsx1} = v;
    endtask

    task automatic t_reset_idle();
        drive_tx(64'h0123_4567_89AB_CDEF);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 24; i++) begin
            dn_data = i[0];
            if (i % 6 == 0) begin
                check("R1 up_data idle", {63'b0, up_data}, 64'd1);
                check("R1 bit_clk idle", {63'b0, bit_clk}, 64'd0);
                check("R1 strobe idle", {63'b0, b1_strobe}, 64'd0);
                check("R1 frame_done idle", {63'b0, frame_done}, 64'd0);
                check("R1 rx reset value", rx_now(), 64'd0);
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Runs one frame of ncyc cycles starting at the current negedge.
    task automatic run_frame(input logic [63:0] txv, input logic [63:0] rxv,
                             input bit use_fs, input bit mid_change, input int ncyc);
        logic exp_du;
        drive_tx(txv);
        if (use_fs) fsync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R9 R10 R11: copy and pulse only after a completed frame
        check("R9 frame_done at frame start", {63'b0, frame_done}, {63'b0, full_pending});
        if (full_pending) hold_exp = pend_rx;
        check("R8 R9 received bytes", rx_now(), hold_exp);
        for (int c = 0; c < ncyc; c++) begin
            exp_du = ((c / 2) < 64) ? txv[63 - (c / 2)] : 1'b1;
            check((c / 2) < 64 ? "R5 R6 up_data bit" : "R7 up_data idle tail",
                  {63'b0, up_data}, {63'b0, exp_du});
            check("R2 R3 bit_clk phase", {63'b0, bit_clk}, {63'b0, c[0]});
            check("R4 b1_strobe window", {63'b0, b1_strobe}, {63'b0, (c < 16)});
            if (c > 0)
                check("R9 frame_done single", {63'b0, frame_done}, 64'd0);
            if (c == 100)
                check("R9 rx stable mid-frame", rx_now(), hold_exp);
            dn_data = ((c / 2) < 64) ? rxv[63 - (c / 2)] : 1'b0;
            if (c == 4) fsync = 1'b0;
            if (mid_change && c == 20) drive_tx(~txv);
            if (c < ncyc - 1) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        full_pending = (ncyc == 192);
        pend_rx = rxv;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset_idle();
        // R2 R5 R8: first framed frame
        run_frame(64'hA5C3_0FF0_1234_8E7D, 64'h5A3C_F00F_EDCB_7182, 1'b1, 1'b0, 192);
        // R6: tx inputs change mid-frame, frame keeps the snapshot
        run_frame(64'h8001_7FFE_C0DE_F00D, 64'hFFFF_0000_AAAA_5555, 1'b1, 1'b1, 192);
        // R10: no sync edge, counter wraps by itself
        run_frame(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 192);
        // R11: sync arrives early, truncated frame
        run_frame(64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 60);
        run_frame(64'hFFFF_FFFF_FFFF_FFFE, 64'h0F1E_2D3C_4B5A_6978, 1'b1, 1'b0, 192);
        run_frame(64'h3C3C_3C3C_C3C3_C3C3, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 192);
        finish_run();
    end
endmodule